// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small accumulator-based processor. It is purely combinational. Each evaluation takes an operation code, the accumulator value, a second operand and the four incoming condition flags. It returns three things: the 8-bit result, the updated flag byte, and a write strobe that tells the register file whether the accumulator should take the result.

The operation set covers the following:
- binary and decimal arithmetic: add and subtract, each with or without the incoming carry, plus increment and decrement;
- the three bitwise logic functions;
- a non-writing compare;
- a decimal adjust that corrects the accumulator after a binary-coded-decimal add or subtract;
- three flag-only or accumulator-only operations: complement accumulator, set carry and complement carry.

Each operation has its own rule for the half-carry flag and for which flags it leaves untouched. For example, the bitwise AND forces half-carry high, and increment and decrement never alter carry.

Top module: `acc_alu`

## Requirements
- R1: `flags_i` carries the incoming flags as {Z,N,H,C} on bits 3..0. `flags_o` is a byte with Z on bit 7, N on bit 6, H on bit 5 and C on bit 4, and its bits 3..0 are always zero.
- R2: `op_i` encodings are as follows: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 decimal adjust, 11 complement accumulator, 12 set carry, 13 complement carry. `wr_en_o` is 1 for every code except 7, 14 and 15.
- R3: Add and add with carry have these rules. The carry-in is the incoming C, used only by code 1. The result is the low 8 bits of acc+opnd+cin. C is bit 8 of that sum. H is the carry out of bit 3, including the carry-in. N is cleared. Z is set when the result is zero.
- R4: Subtract and subtract with carry have these rules. The borrow-in is the incoming C, used only by code 3. The result is the low 8 bits of acc-opnd-bin. C is set on a borrow out of bit 7. H is set on a borrow out of bit 3, including the borrow-in. N is set. Z is set when the result is zero.
- R5: Compare produces exactly the flags of subtract. `res_o` shows the difference and `wr_en_o` is 0.
- R6: AND sets H and clears N and C. Z is set when the result is zero.
- R7: XOR and OR clear H, N and C. Z is set when the result is zero.
- R8: Increment returns acc+1 (mod 256). It clears N, sets H when the low nibble of the result is zero, sets Z when the result is zero, and passes C through unchanged.
- R9: Decrement returns acc-1 (mod 256). It sets N, sets H when the low nibble of result+1 is zero, sets Z when the result is zero, and passes C through unchanged.
- R10: Decimal adjust with N clear works in two steps. First it adds 0x06 when H is set or the accumulator's low nibble exceeds 9. Then it adds 0x60 when C is set or the intermediate value exceeds 0x9F.
- R11: Decimal adjust with N set subtracts 0x06 (mod 256) when H is set, then subtracts 0x60 when C is set. For both N values, decimal adjust clears H and keeps N. It sets C if C was set or if the add path carried past bit 7, and sets Z from the adjusted byte.
- R12: Complement accumulator returns the bitwise inverse of acc. It sets N and H and keeps Z and C.
- R13: Set carry sets C, and complement carry inverts C. Both clear N and H, keep Z, and return acc unchanged.
- R14: Codes 14 and 15 return acc unchanged, pass all four flags through and hold `wr_en_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (R2) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 8 | Operation result |
| flags_o | output | 8 | Updated flag byte {Z,N,H,C,0000} |
| wr_en_o | output | 1 | Accumulator write strobe |

## Verification
The bench targets the half-carry boundaries, checking that the carry-in or borrow-in reaches bit 3. A unit that ignored it would miss H on 0x0F+0x00+1 and on 0x00-0x00-1. It drives increment and decrement with C already set, where a unit that reused the adder carry would clear it. It also sends the subtract-path decimal adjust through a low-nibble wrap with C clear, where a unit that derived carry from the raw difference would set it. Compare and the reserved codes are checked for a low write strobe and for unaltered flags, and a swept pattern checks add and subtract against arithmetic computed in the bench.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CP   = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_DAA  = 4'd10,
    OP_CPL  = 4'd11,
    OP_SCF  = 4'd12,
    OP_CCF  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  // positions inside the incoming nibble
  localparam int FI_Z = 3;
  localparam int FI_N = 2;
  localparam int FI_H = 1;
  localparam int FI_C = 0;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W  = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o
);
  localparam int HW = W - NW;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [NW:0]   lo_sum;
  logic [HW:0]   hi_sum;

  // subtraction is a + ~b + ~borrow; carries come out inverted
  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    c_eff  = sub_i ? ~cin_i : cin_i;
    lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
    hi_sum = {1'b0, a_i[W-1:NW]} + {1'b0, b_eff[W-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
    sum_o  = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
    hc_o   = sub_i ? ~lo_sum[NW] : lo_sum[NW];
    cy_o   = sub_i ? ~hi_sum[HW] : hi_sum[HW];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, sub_i})) begin
      AST_SUB_BORROW: assert (!(sub_i && !cin_i) || (cy_o == (a_i < b_i)))
        else $error("plain subtract borrow disagrees with magnitude compare"); // R4
    end
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  acc_alu_pkg::logic_sel_e sel_i,
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            b_i,
  output logic [W-1:0]            res_o
);
  import acc_alu_pkg::*;

  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic         n_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int TW = W + 2;
  localparam logic [TW-1:0] LO_FIX = TW'(6);
  localparam logic [TW-1:0] HI_FIX = TW'(96);
  localparam logic [TW-1:0] HI_LIM = TW'(159);
  localparam logic [TW-1:0] BYTE_M = TW'((1 << W) - 1);

  logic [TW-1:0] tmp;

  always_comb begin
    tmp = {2'b00, acc_i};
    if (n_i) begin
      if (h_i) tmp = (tmp - LO_FIX) & BYTE_M;
      if (c_i) tmp = tmp - HI_FIX;
    end else begin
      if (h_i || (tmp[3:0] > 4'd9)) tmp = tmp + LO_FIX;
      if (c_i || (tmp > HI_LIM))    tmp = tmp + HI_FIX;
    end
    res_o = tmp[W-1:0];
    c_o   = c_i | (~n_i & tmp[W]);
  end

  always_comb begin
    if (!$isunknown({acc_i, n_i, h_i, c_i})) begin
      AST_DAA_SUB_NO_NEW_CARRY: assert (!(n_i && !c_i) || !c_o)
        else $error("subtract-side adjust raised carry"); // R11
      AST_DAA_CARRY_STICKY: assert (!c_i || c_o)
        else $error("adjust dropped an incoming carry"); // R11
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [3:0] flags_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);
  import acc_alu_pkg::*;

  alu_op_e     op;
  logic        z_in, n_in, h_in, c_in;
  logic [DATA_W-1:0] as_b, as_sum, lg_res, bcd_res;
  logic        as_cin, as_sub, as_cy, as_hc, bcd_cy;
  logic_sel_e  lg_sel;
  logic        fz, fn, fh, fc;

  always_comb begin
    op   = alu_op_e'(op_i);
    z_in = flags_i[FI_Z];
    n_in = flags_i[FI_N];
    h_in = flags_i[FI_H];
    c_in = flags_i[FI_C];
  end

  // shared adder operand steering
  always_comb begin
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC: as_cin = c_in;
      OP_SUB, OP_CP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = c_in; end
      OP_INC: as_b = DATA_W'(1);
      OP_DEC: begin as_b = DATA_W'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_XOR:  lg_sel = LG_XOR;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_AND;
    endcase
  end

  acc_alu_addsub #(.W(DATA_W), .NW(NIB_W)) u_addsub (
    .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .cy_o(as_cy), .hc_o(as_hc)
  );

  acc_alu_logic #(.W(DATA_W)) u_logic (
    .sel_i(lg_sel), .a_i(acc_i), .b_i(opnd_i), .res_o(lg_res)
  );

  acc_alu_bcd #(.W(DATA_W)) u_bcd (
    .acc_i(acc_i), .n_i(n_in), .h_i(h_in), .c_i(c_in),
    .res_o(bcd_res), .c_o(bcd_cy)
  );

  always_comb begin
    res_o   = acc_i;
    fz      = z_in;
    fn      = n_in;
    fh      = h_in;
    fc      = c_in;
    wr_en_o = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res_o = as_sum; fz = (as_sum == '0); fn = 1'b0; fh = as_hc; fc = as_cy;
      end
      OP_SUB, OP_SBC, OP_CP: begin
        res_o = as_sum; fz = (as_sum == '0); fn = 1'b1; fh = as_hc; fc = as_cy;
        wr_en_o = (op != OP_CP);
      end
      OP_AND: begin
        res_o = lg_res; fz = (lg_res == '0); fn = 1'b0; fh = 1'b1; fc = 1'b0;
      end
      OP_XOR, OP_OR: begin
        res_o = lg_res; fz = (lg_res == '0); fn = 1'b0; fh = 1'b0; fc = 1'b0;
      end
      OP_INC: begin
        res_o = as_sum; fz = (as_sum == '0); fn = 1'b0; fh = as_hc;
      end
      OP_DEC: begin
        res_o = as_sum; fz = (as_sum == '0); fn = 1'b1; fh = as_hc;
      end
      OP_DAA: begin
        res_o = bcd_res; fz = (bcd_res == '0); fh = 1'b0; fc = bcd_cy;
      end
      OP_CPL: begin
        res_o = ~acc_i; fn = 1'b1; fh = 1'b1;
      end
      OP_SCF: begin
        fn = 1'b0; fh = 1'b0; fc = 1'b1;
      end
      OP_CCF: begin
        fn = 1'b0; fh = 1'b0; fc = ~c_in;
      end
      default: wr_en_o = 1'b0;
    endcase
    flags_o = {fz, fn, fh, fc, 4'b0000};
  end

  always_comb begin
    if (!$isunknown({op_i, acc_i, opnd_i, flags_i})) begin
      AST_INCDEC_KEEP_C: assert (!(op == OP_INC || op == OP_DEC) || (flags_o[4] == flags_i[FI_C]))
        else $error("increment/decrement altered carry"); // R8
      AST_LOGIC_CLEAR_NC: assert (!(op == OP_AND || op == OP_XOR || op == OP_OR) || (flags_o[6] == 1'b0 && flags_o[4] == 1'b0))
        else $error("logic op left N or C set"); // R6
      AST_ZERO_TRACKS_RESULT: assert (!(op_i <= 4'd10) || (flags_o[7] == (res_o == 8'h00)))
        else $error("Z disagrees with the result byte"); // R3
      AST_RESERVED_QUIET: assert (!(op_i >= 4'd14) || (!wr_en_o && flags_o[7:4] == flags_i))
        else $error("reserved code changed state"); // R14
    end
  end
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [3:0] flags_i = 4'h0;
  logic [7:0] res_o, flags_o;
  logic       wr_en_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu u_dut (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .wr_en_o(wr_en_o)
  );

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] f);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; flags_i = f;
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] er, input logic [7:0] ef,
                       input logic ew);
    checks++;
    if (res_o !== er || flags_o !== ef || wr_en_o !== ew) begin
      errors++;
      $display("FAIL %s: res=%h flags=%h we=%b expected res=%h flags=%h we=%b",
               tag, res_o, flags_o, wr_en_o, er, ef, ew);
    end
  endtask

  task automatic t_first;
    apply(4'd0, 8'h00, 8'h00, 4'h0); check("R1 zero inputs add", 8'h00, 8'h80, 1'b1);
  endtask

  task automatic t_add;
    apply(4'd0, 8'h3A, 8'hC6, 4'h0); check("R3 add wrap", 8'h00, 8'hB0, 1'b1);
    apply(4'd0, 8'h12, 8'h34, 4'h1); check("R3 add ignores carry", 8'h46, 8'h00, 1'b1);
    apply(4'd1, 8'h0F, 8'h00, 4'h1); check("R3 adc half from cin", 8'h10, 8'h20, 1'b1);
  endtask

  task automatic t_sub;
    apply(4'd2, 8'h3E, 8'h3E, 4'h0); check("R4 sub equal", 8'h00, 8'hC0, 1'b1);
    apply(4'd2, 8'h10, 8'h01, 4'h0); check("R4 sub nibble borrow", 8'h0F, 8'h60, 1'b1);
    apply(4'd3, 8'h00, 8'h00, 4'h1); check("R4 sbc borrow-in", 8'hFF, 8'h70, 1'b1);
  endtask

  task automatic t_cp;
    apply(4'd7, 8'h20, 8'h30, 4'h0); check("R5 compare", 8'hF0, 8'h50, 1'b0);
    apply(4'd7, 8'h42, 8'h42, 4'h1); check("R5 compare equal", 8'h00, 8'hC0, 1'b0);
  endtask

  task automatic t_logic;
    apply(4'd4, 8'h5A, 8'hA5, 4'h1); check("R6 and zero", 8'h00, 8'hA0, 1'b1);
    apply(4'd4, 8'hF0, 8'h3C, 4'hF); check("R6 and", 8'h30, 8'h20, 1'b1);
    apply(4'd5, 8'hFF, 8'h0F, 4'hF); check("R7 xor", 8'hF0, 8'h00, 1'b1);
    apply(4'd6, 8'h00, 8'h00, 4'h7); check("R7 or zero", 8'h00, 8'h80, 1'b1);
  endtask

  task automatic t_incdec;
    apply(4'd8, 8'h0F, 8'h55, 4'h1); check("R8 inc nibble wrap keeps C", 8'h10, 8'h30, 1'b1);
    apply(4'd8, 8'hFF, 8'h00, 4'h0); check("R8 inc to zero", 8'h00, 8'hA0, 1'b1);
    apply(4'd9, 8'h10, 8'h00, 4'h1); check("R9 dec nibble borrow keeps C", 8'h0F, 8'h70, 1'b1);
    apply(4'd9, 8'h01, 8'h00, 4'h0); check("R9 dec to zero", 8'h00, 8'hC0, 1'b1);
  endtask

  task automatic t_daa_add;
    apply(4'd10, 8'h7D, 8'h00, 4'h0); check("R10 low fix", 8'h83, 8'h00, 1'b1);
    apply(4'd10, 8'h9A, 8'h00, 4'h0); check("R10 both fixes carry", 8'h00, 8'h90, 1'b1);
    apply(4'd10, 8'h02, 8'h00, 4'h2); check("R10 fix from H", 8'h08, 8'h00, 1'b1);
  endtask

  task automatic t_daa_sub;
    apply(4'd10, 8'hFA, 8'h00, 4'h7); check("R11 sub both fixes", 8'h94, 8'h50, 1'b1);
    apply(4'd10, 8'h06, 8'h00, 4'h6); check("R11 sub to zero", 8'h00, 8'hC0, 1'b1);
    apply(4'd10, 8'h05, 8'h00, 4'h6); check("R11 sub wrap no carry", 8'hFF, 8'h40, 1'b1);
  endtask

  task automatic t_cpl;
    apply(4'd11, 8'h35, 8'h00, 4'h9); check("R12 cpl keeps Z C", 8'hCA, 8'hF0, 1'b1);
    apply(4'd11, 8'hFF, 8'h00, 4'h0); check("R12 cpl", 8'h00, 8'h60, 1'b1);
  endtask

  task automatic t_carry_ops;
    apply(4'd12, 8'h11, 8'h00, 4'hE); check("R13 scf", 8'h11, 8'h90, 1'b1);
    apply(4'd13, 8'h22, 8'h00, 4'h5); check("R13 ccf clear", 8'h22, 8'h00, 1'b1);
    apply(4'd13, 8'h33, 8'h00, 4'hA); check("R13 ccf set", 8'h33, 8'h90, 1'b1);
  endtask

  task automatic t_reserved;
    apply(4'd14, 8'h77, 8'h12, 4'hA); check("R14 code 14", 8'h77, 8'hA0, 1'b0);
    apply(4'd15, 8'h88, 8'h34, 4'h5); check("R14 code 15 R2", 8'h88, 8'h50, 1'b0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 64; i++) begin
      int a, b, c, s, d;
      logic [7:0] ef;
      a = (i * 37 + 11) % 256;
      b = (i * 101 + 3) % 256;
      c = i % 2;
      s = a + b + c;
      ef = {((s % 256) == 0), 1'b0, (((a % 16) + (b % 16) + c) > 15), (s > 255), 4'h0};
      apply(4'd1, a[7:0], b[7:0], {3'b000, c[0]});
      check("R3 adc sweep", s[7:0], ef, 1'b1);
      d = a - b - c;
      ef = {((d & 255) == 0), 1'b1, (((a % 16) - (b % 16) - c) < 0), (d < 0), 4'h0};
      apply(4'd3, a[7:0], b[7:0], {3'b000, c[0]});
      check("R4 sbc sweep", d[7:0], ef, 1'b1);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_first();
    t_add();
    t_sub();
    t_cp();
    t_logic();
    t_incdec();
    t_daa_add();
    t_daa_sub();
    t_cpl();
    t_carry_ops();
    t_reserved();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule